// File: doc/BRIEF.md
# Disk Controller Host Handshake Engine

This block sits between a byte-wide host bus and the command execution logic of a disk controller. The host sees one status byte and one data byte. It writes a command code, then feeds a number of parameter bytes that depends on the command, and waits while the command runs. It then reads back result bytes. Every step is paced by the ready and direction flags in the status byte.

Execution itself is outside the block. The engine announces a start with a one-cycle strobe and forwards each parameter byte as it arrives. It waits for a completion strobe that comes with a flat buffer of result bytes. Seek-busy flags from the drives show in the low status nibble and restrict which commands are accepted. An abort code cancels a running command.

Top module: `host_handshake_engine`

## Requirements
- R1: After reset the status byte is 0x80 when no drive is seeking, the data byte is 0x00 and irq_o is low. Status bit order from bit 7 down is: ready (TXR), direction to host (DIR), non-DMA flag, busy, then seek-busy for drives 3 to 0.
- R2: The command is selected by bits [4:0] of the code byte, and bits [7:5] are ignored. The table gives parameter and result counts as follows. 0x06 and 0x05 take 8 parameters and return 7 results. 0x0A takes 1 parameter and returns 7 results. 0x04 takes 1 and returns 1. 0x08 takes 0 and returns 2. 0x03 takes 2 and returns 0. 0x0B takes 1 and returns 0. 0x0F takes 2 and returns 0. 0x07 takes 1 and returns 0. 0x0E takes 0 and returns 0. 0x1F aborts.
- R3: While the engine awaits a parameter, status bit 7 is 1. It drops to 0 for one cycle after each byte is accepted. Each accepted byte appears on param_o with a one-cycle param_valid_o. After the last parameter, no request is made and exec_start_o pulses for one cycle.
- R4: When a result byte is presented, status bits 7 and 6 are both 1 and data_o holds the byte. A data read clears both bits for one cycle before the next byte is presented.
- R5: The engine returns to idle after the last result byte is read, or on exec_done_i for a command without results. On return, data_o is the dummy byte 0x00, status bit 7 is 1, and bits 6 and 4 are 0.
- R6: irq_o rises together with the first result byte of 0x06, 0x05 and 0x0A only. It falls when that byte is read and is not raised again for later bytes. The 0x04 and 0x08 results never raise it.
- R7: An unknown code returns exactly one result byte, 0x80, with irq_o low.
- R8: While any seek-busy bit is set, only 0x04, 0x08, 0x0F, 0x07 and 0x1F are accepted. Any other code is answered as in R7.
- R9: For 0x0F and 0x07, bits [1:0] of the first parameter select a drive. If that drive's seek-busy bit is set, the command is answered as in R7 and nothing is started.
- R10: Writing 0x1F while idle, executing or returning results pulses exec_abort_o and returns the engine to idle.
- R11: A data read while idle is taken as issuing the data byte (0x00) as a command, so it yields the R7 response.
- R12: Status bit 5 follows ndm_i and status bits [3:0] follow seek_busy_i in every state.
- R13: Status bit 4 (busy) is 1 from the cycle after a command write until the return to idle. In the decode cycle right after the write, status reads 0x10 plus the seek bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_i | input | 1 | Host writes host_din_i to the data register |
| host_rd_i | input | 1 | Host reads the data register |
| host_din_i | input | 8 | Host write data |
| status_o | output | 8 | Status byte |
| data_o | output | 8 | Data register as seen by the host |
| irq_o | output | 1 | Interrupt request |
| seek_busy_i | input | 4 | Per-drive seek in progress |
| ndm_i | input | 1 | Non-DMA mode flag mirrored into status |
| param_o | output | 8 | Accepted parameter byte |
| param_valid_o | output | 1 | One-cycle strobe for param_o |
| exec_start_o | output | 1 | One-cycle strobe to start execution |
| exec_code_o | output | 8 | Latched command code |
| exec_done_i | input | 1 | Execution complete strobe |
| exec_result_i | input | 56 | Result bytes, byte 0 in bits [7:0] |
| exec_abort_o | output | 1 | One-cycle strobe when a command is aborted |

## Verification
A wrong sequencer state shows up in the status byte on the very next cycle after a host access. Examples are a busy flag stuck high, a missing one-cycle ready gap, or the direction flag set during parameter collection. A wrong byte count from the table shows up either as an early start strobe or as a host read that returns the dummy byte instead of a result. An interrupt that is mis-gated shows on irq_o at the first result byte or at the read that follows it. An exhaustive sweep of all 32 opcodes, with drives free and with one drive seeking, exposes every such error within one command.

// File: rtl/hs_pkg.sv
package hs_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_DRV   = 4;
    localparam int DRV_W     = $clog2(NUM_DRV);
    localparam int MAX_PARAM = 8;
    localparam int MAX_RES   = 7;
    localparam int PCNT_W    = $clog2(MAX_PARAM + 1);
    localparam int RCNT_W    = $clog2(MAX_RES + 1);
    localparam int OP_W      = 5;
    localparam int STAT_W    = 4 + NUM_DRV;

    localparam logic [BYTE_W-1:0] DUMMY_BYTE   = 8'h00;
    localparam logic [BYTE_W-1:0] INVALID_BYTE = 8'h80;
    localparam logic [OP_W-1:0]   OP_ABORT     = 5'h1F;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DECODE, ST_PARAM, ST_PGAP, ST_EXEC, ST_RES, ST_RGAP
    } hs_state_e;

    typedef enum logic [2:0] {
        K_INVALID, K_PLAIN, K_CHECK, K_SEEK, K_ABORT
    } cmd_kind_e;

    typedef struct packed {
        logic [PCNT_W-1:0] n_param;
        logic [RCNT_W-1:0] n_res;
        logic              irq;
        cmd_kind_e         kind;
    } cmd_info_t;

    function automatic cmd_info_t mk_info(input int np, input int nr,
                                          input logic irq, input cmd_kind_e kind);
        cmd_info_t i;
        i.n_param = PCNT_W'(np);
        i.n_res   = RCNT_W'(nr);
        i.irq     = irq;
        i.kind    = kind;
        return i;
    endfunction

    function automatic cmd_info_t invalid_info();
        return mk_info(0, 1, 1'b0, K_INVALID);
    endfunction

    function automatic cmd_info_t lookup(input logic [OP_W-1:0] op);
        cmd_info_t i;
        case (op)
            5'h06:   i = mk_info(8, 7, 1'b1, K_PLAIN);
            5'h05:   i = mk_info(8, 7, 1'b1, K_PLAIN);
            5'h0A:   i = mk_info(1, 7, 1'b1, K_PLAIN);
            5'h04:   i = mk_info(1, 1, 1'b0, K_CHECK);
            5'h08:   i = mk_info(0, 2, 1'b0, K_CHECK);
            5'h03:   i = mk_info(2, 0, 1'b0, K_PLAIN);
            5'h0B:   i = mk_info(1, 0, 1'b0, K_PLAIN);
            5'h0F:   i = mk_info(2, 0, 1'b0, K_SEEK);
            5'h07:   i = mk_info(1, 0, 1'b0, K_SEEK);
            5'h0E:   i = mk_info(0, 0, 1'b0, K_PLAIN);
            5'h1F:   i = mk_info(0, 0, 1'b0, K_ABORT);
            default: i = invalid_info();
        endcase
        return i;
    endfunction

    function automatic logic [STAT_W-1:0] status_pack(input hs_state_e st, input logic ndm,
                                                      input logic [NUM_DRV-1:0] busy);
        logic txr, dir, bsy;
        txr = (st == ST_IDLE) || (st == ST_PARAM) || (st == ST_RES);
        dir = (st == ST_RES);
        bsy = (st != ST_IDLE);
        return {txr, dir, ndm, bsy, busy};
    endfunction

endpackage

// File: rtl/hs_decode.sv
module hs_decode
    import hs_pkg::*;
(
    input  logic [BYTE_W-1:0]  code_i,
    input  logic [NUM_DRV-1:0] seek_busy_i,
    output cmd_info_t          info_o
);
    cmd_info_t raw;
    logic      any_busy;
    logic      allowed;

    always_comb begin
        raw      = lookup(code_i[OP_W-1:0]);
        any_busy = |seek_busy_i;
        allowed  = (raw.kind == K_CHECK) || (raw.kind == K_SEEK) || (raw.kind == K_ABORT);
        info_o   = (any_busy && !allowed) ? invalid_info() : raw;
    end
endmodule

// File: rtl/hs_result_buf.sv
module hs_result_buf
    import hs_pkg::*;
#(
    parameter int SLOTS = MAX_RES
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cap_exec_i,
    input  logic                    cap_inv_i,
    input  logic [SLOTS*BYTE_W-1:0] flat_i,
    input  logic [RCNT_W-1:0]       idx_i,
    output logic [BYTE_W-1:0]       byte_o
);
    logic [BYTE_W-1:0] slot_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (cap_exec_i) begin
                slot_q[g] <= flat_i[g*BYTE_W +: BYTE_W];
            end else if (cap_inv_i && g == 0) begin
                slot_q[g] <= INVALID_BYTE;
            end
        end
    end

    always_comb begin
        byte_o = DUMMY_BYTE;
        for (int k = 0; k < SLOTS; k++) begin
            if (idx_i == RCNT_W'(k)) byte_o = slot_q[k];
        end
    end
endmodule

// File: rtl/hs_seq.sv
module hs_seq
    import hs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr_i,
    input  logic               host_rd_i,
    input  logic [BYTE_W-1:0]  host_din_i,
    input  logic [NUM_DRV-1:0] seek_busy_i,
    input  cmd_info_t          info_i,
    input  logic               exec_done_i,
    output hs_state_e          state_o,
    output logic [BYTE_W-1:0]  code_o,
    output logic [RCNT_W-1:0]  idx_o,
    output logic               cap_exec_o,
    output logic               cap_inv_o,
    output logic               irq_o,
    output logic [BYTE_W-1:0]  param_o,
    output logic               param_valid_o,
    output logic               exec_start_o,
    output logic               exec_abort_o
);
    hs_state_e         state;
    logic [BYTE_W-1:0] code_q;
    cmd_info_t         info_q;
    logic [PCNT_W-1:0] cnt_q;
    logic              first_q;
    logic [RCNT_W-1:0] idx_q;
    logic              irq_q;
    logic [BYTE_W-1:0] param_q;
    logic              pvld_q;
    logic              start_q;
    logic              abort_q;

    logic abort_wr;
    logic seek_reject;

    always_comb begin
        abort_wr    = host_wr_i && (host_din_i[OP_W-1:0] == OP_ABORT);
        seek_reject = (state == ST_PARAM) && host_wr_i && first_q &&
                      (info_q.kind == K_SEEK) && seek_busy_i[host_din_i[DRV_W-1:0]];
        cap_inv_o   = ((state == ST_DECODE) && (info_i.kind == K_INVALID)) || seek_reject;
        cap_exec_o  = (state == ST_EXEC) && !abort_wr && exec_done_i && (info_q.n_res != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            code_q  <= DUMMY_BYTE;
            info_q  <= invalid_info();
            cnt_q   <= '0;
            first_q <= 1'b0;
            idx_q   <= '0;
            irq_q   <= 1'b0;
            param_q <= '0;
            pvld_q  <= 1'b0;
            start_q <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            pvld_q  <= 1'b0;
            start_q <= 1'b0;
            abort_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (host_wr_i) begin
                        code_q <= host_din_i;
                        state  <= ST_DECODE;
                    end else if (host_rd_i) begin
                        code_q <= DUMMY_BYTE;
                        state  <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    info_q <= info_i;
                    if (info_i.kind == K_ABORT) begin
                        abort_q <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (info_i.kind == K_INVALID) begin
                        idx_q <= '0;
                        irq_q <= 1'b0;
                        state <= ST_RES;
                    end else if (info_i.n_param != '0) begin
                        cnt_q   <= info_i.n_param;
                        first_q <= 1'b1;
                        state   <= ST_PARAM;
                    end else begin
                        start_q <= 1'b1;
                        state   <= ST_EXEC;
                    end
                end
                ST_PARAM: begin
                    if (host_wr_i) begin
                        if (seek_reject) begin
                            info_q <= invalid_info();
                            idx_q  <= '0;
                            irq_q  <= 1'b0;
                            state  <= ST_RES;
                        end else begin
                            param_q <= host_din_i;
                            pvld_q  <= 1'b1;
                            first_q <= 1'b0;
                            cnt_q   <= cnt_q - 1'b1;
                            if (cnt_q == PCNT_W'(1)) begin
                                start_q <= 1'b1;
                                state   <= ST_EXEC;
                            end else begin
                                state <= ST_PGAP;
                            end
                        end
                    end
                end
                ST_PGAP: state <= ST_PARAM;
                ST_EXEC: begin
                    if (abort_wr) begin
                        abort_q <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (exec_done_i) begin
                        if (info_q.n_res == '0) begin
                            state <= ST_IDLE;
                        end else begin
                            idx_q <= '0;
                            irq_q <= info_q.irq;
                            state <= ST_RES;
                        end
                    end
                end
                ST_RES: begin
                    if (abort_wr) begin
                        abort_q <= 1'b1;
                        irq_q   <= 1'b0;
                        state   <= ST_IDLE;
                    end else if (host_rd_i) begin
                        irq_q <= 1'b0;
                        if (idx_q == info_q.n_res - 1'b1) begin
                            state <= ST_IDLE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            state <= ST_RGAP;
                        end
                    end
                end
                ST_RGAP: state <= ST_RES;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign state_o       = state;
    assign code_o        = code_q;
    assign idx_o         = idx_q;
    assign irq_o         = irq_q;
    assign param_o       = param_q;
    assign param_valid_o = pvld_q;
    assign exec_start_o  = start_q;
    assign exec_abort_o  = abort_q;

    // R6: interrupt only while a result byte is on offer
    p_irq_in_result_r6: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (state == ST_RES));

    // R6: a result read always lowers the interrupt
    p_irq_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RES && host_rd_i && !abort_wr) |=> !irq_q);

    // R3: start follows the decode cycle or the last parameter
    p_start_origin_r3: assert property (@(posedge clk) disable iff (rst)
        start_q |-> ($past(state) == ST_DECODE || $past(state) == ST_PARAM));

    // R3: a forwarded parameter comes from a host write
    p_param_from_write_r3: assert property (@(posedge clk) disable iff (rst)
        pvld_q |-> $past(host_wr_i));

    // R10: abort during execution or results lands in idle
    p_abort_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (abort_wr && (state == ST_EXEC || state == ST_RES)) |=> (state == ST_IDLE && abort_q));
endmodule

// File: rtl/host_handshake_engine.sv
module host_handshake_engine
    import hs_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      host_wr_i,
    input  logic                      host_rd_i,
    input  logic [7:0]                host_din_i,
    output logic [7:0]                status_o,
    output logic [7:0]                data_o,
    output logic                      irq_o,
    input  logic [3:0]                seek_busy_i,
    input  logic                      ndm_i,
    output logic [7:0]                param_o,
    output logic                      param_valid_o,
    output logic                      exec_start_o,
    output logic [7:0]                exec_code_o,
    input  logic                      exec_done_i,
    input  logic [MAX_RES*8-1:0]      exec_result_i,
    output logic                      exec_abort_o
);
    hs_state_e         state;
    logic [BYTE_W-1:0] code;
    cmd_info_t         info;
    logic [RCNT_W-1:0] idx;
    logic              cap_exec;
    logic              cap_inv;
    logic [BYTE_W-1:0] res_byte;

    hs_decode u_decode (
        .code_i      (code),
        .seek_busy_i (seek_busy_i),
        .info_o      (info)
    );

    hs_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .host_wr_i     (host_wr_i),
        .host_rd_i     (host_rd_i),
        .host_din_i    (host_din_i),
        .seek_busy_i   (seek_busy_i),
        .info_i        (info),
        .exec_done_i   (exec_done_i),
        .state_o       (state),
        .code_o        (code),
        .idx_o         (idx),
        .cap_exec_o    (cap_exec),
        .cap_inv_o     (cap_inv),
        .irq_o         (irq_o),
        .param_o       (param_o),
        .param_valid_o (param_valid_o),
        .exec_start_o  (exec_start_o),
        .exec_abort_o  (exec_abort_o)
    );

    hs_result_buf #(.SLOTS(MAX_RES)) u_rbuf (
        .clk        (clk),
        .rst        (rst),
        .cap_exec_i (cap_exec),
        .cap_inv_i  (cap_inv),
        .flat_i     (exec_result_i),
        .idx_i      (idx),
        .byte_o     (res_byte)
    );

    assign status_o    = status_pack(state, ndm_i, seek_busy_i);
    assign data_o      = (state == ST_RES) ? res_byte : DUMMY_BYTE;
    assign exec_code_o = code;

    // R1: with busy low the engine is ready for a code and not returning data
    p_idle_status_r1: assert property (@(posedge clk) disable iff (rst)
        !status_o[4] |-> (status_o[7] && !status_o[6] && data_o == DUMMY_BYTE));

    // R4: direction to host is only shown together with ready
    p_dir_needs_txr_r4: assert property (@(posedge clk) disable iff (rst)
        status_o[6] |-> (status_o[7] && status_o[4]));

    // R12: seek bits are mirrored
    p_seek_mirror_r12: assert property (@(posedge clk) disable iff (rst)
        status_o[3:0] == seek_busy_i);
endmodule

// File: tb/tb_host_handshake_engine.sv
module tb_host_handshake_engine;
    localparam int CLK_PERIOD = 10;
    localparam int KI = 0, KP = 1, KC = 2, KS = 3, KA = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_din = 8'h00;
    logic [3:0]  seek_busy = 4'h0;
    logic        ndm = 1'b0;
    logic        exec_done = 1'b0;
    logic [55:0] exec_result = '0;
    logic [7:0]  status, data, param, exec_code;
    logic        irq, param_valid, exec_start, exec_abort;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    host_handshake_engine dut (
        .clk(clk), .rst(rst), .host_wr_i(host_wr), .host_rd_i(host_rd),
        .host_din_i(host_din), .status_o(status), .data_o(data), .irq_o(irq),
        .seek_busy_i(seek_busy), .ndm_i(ndm), .param_o(param),
        .param_valid_o(param_valid), .exec_start_o(exec_start),
        .exec_code_o(exec_code), .exec_done_i(exec_done),
        .exec_result_i(exec_result), .exec_abort_o(exec_abort)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask
    task automatic wr(input logic [7:0] b);
        host_wr = 1'b1; host_din = b; tick(); host_wr = 1'b0;
    endtask
    task automatic rd();
        host_rd = 1'b1; tick(); host_rd = 1'b0;
    endtask
    task automatic pulse_done();
        exec_done = 1'b1; tick(); exec_done = 1'b0;
    endtask

    function automatic logic [7:0] rbyte(input logic [7:0] code, input int j);
        return code ^ 8'((j + 1) * 33);
    endfunction

    function automatic logic [7:0] sbv();
        return {4'h0, seek_busy};
    endfunction

    // expected table per R2, gating per R8
    function automatic void model(input logic [4:0] op, input logic busy,
                                  output int np, output int nr, output logic irqf, output int kind);
        np = 0; nr = 1; irqf = 1'b0; kind = KI;
        case (op)
            5'h06, 5'h05: begin np = 8; nr = 7; irqf = 1'b1; kind = KP; end
            5'h0A:        begin np = 1; nr = 7; irqf = 1'b1; kind = KP; end
            5'h04:        begin np = 1; nr = 1; kind = KC; end
            5'h08:        begin np = 0; nr = 2; kind = KC; end
            5'h03:        begin np = 2; nr = 0; kind = KP; end
            5'h0B:        begin np = 1; nr = 0; kind = KP; end
            5'h0F:        begin np = 2; nr = 0; kind = KS; end
            5'h07:        begin np = 1; nr = 0; kind = KS; end
            5'h0E:        begin np = 0; nr = 0; kind = KP; end
            5'h1F:        begin np = 0; nr = 0; kind = KA; end
            default: ;
        endcase
        if (busy && !(kind == KC || kind == KS || kind == KA)) begin
            np = 0; nr = 1; irqf = 1'b0; kind = KI;
        end
    endfunction

    // read nr result bytes, engine already presenting the first one
    task automatic read_results(input int nr, input logic irqf, input logic inv, input logic [7:0] code);
        for (int j = 0; j < nr; j++) begin
            chk("R4 result status", status, 8'hD0 | sbv());
            chk(inv ? "R7 invalid byte" : "R4 result byte", data, inv ? 8'h80 : rbyte(code, j));
            chk("R6 irq with result", {7'b0, irq}, {7'b0, (j == 0) && irqf});
            rd();
            if (j < nr - 1) begin
                chk("R4 gap after read", status, 8'h10 | sbv());
                chk("R6 irq dropped", {7'b0, irq}, 8'h00);
                tick();
            end
        end
        chk("R5 idle status", status, 8'h80 | sbv());
        chk("R5 dummy byte", data, 8'h00);
        chk("R6 irq low in idle", {7'b0, irq}, 8'h00);
    endtask

    task automatic run_cmd(input logic [7:0] code, input logic [7:0] p0);
        int np, nr, kind;
        logic irqf;
        model(code[4:0], |seek_busy, np, nr, irqf, kind);
        wr(code);
        chk("R13 decode status", status, 8'h10 | sbv());
        tick();
        if (kind == KA) begin
            chk("R10 abort strobe", {7'b0, exec_abort}, 8'h01);
            chk("R10 idle after abort", status, 8'h80 | sbv());
            return;
        end
        if (kind == KI) begin
            read_results(1, 1'b0, 1'b1, code);
            return;
        end
        for (int i = 0; i < np; i++) begin
            logic [7:0] pb;
            pb = (i == 0) ? p0 : 8'(8'h40 + i);
            chk("R3 param request", status, 8'h90 | sbv());
            wr(pb);
            chk("R3 param strobe", {7'b0, param_valid}, 8'h01);
            chk("R3 param byte", param, pb);
            if (i < np - 1) begin
                chk("R3 txr gap", status, 8'h10 | sbv());
                tick();
            end
        end
        chk("R3 exec start", {7'b0, exec_start}, 8'h01);
        chk("R2 exec code", exec_code, code);
        chk("R13 busy in exec", status, 8'h10 | sbv());
        tick();
        chk("R13 busy held", status, 8'h10 | sbv());
        for (int j = 0; j < 7; j++) exec_result[j*8 +: 8] = rbyte(code, j);
        pulse_done();
        if (nr == 0) begin
            chk("R5 idle after no-result cmd", status, 8'h80 | sbv());
            chk("R5 dummy byte", data, 8'h00);
        end else begin
            read_results(nr, irqf, 1'b0, code);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick(); tick();
        rst = 1'b0;
        tick();
        chk("R1 reset status", status, 8'h80);
        chk("R1 reset data", data, 8'h00);
        chk("R1 reset irq", {7'b0, irq}, 8'h00);

        // exhaustive opcode sweep, drives free; upper code bits vary (R2)
        for (int op = 0; op < 32; op++) run_cmd(8'(((op % 3) << 5) | op), 8'h00);

        // same sweep with drive 1 seeking (R8)
        seek_busy = 4'b0010;
        tick();
        chk("R12 seek bits mirrored", status, 8'h82);
        for (int op = 0; op < 32; op++) run_cmd(8'(op), 8'h00);

        // R9: seek and recalibrate to the busy drive are refused
        wr(8'h0F); tick();
        chk("R9 seek param request", status, 8'h92);
        wr(8'h01);
        chk("R9 no param forwarded", {7'b0, param_valid}, 8'h00);
        read_results(1, 1'b0, 1'b1, 8'h0F);
        wr(8'h07); tick();
        wr(8'h05);
        read_results(1, 1'b0, 1'b1, 8'h07);
        run_cmd(8'h07, 8'h02);   // R9 free drive accepted
        seek_busy = 4'h0;
        tick();

        // R11: data read while idle
        rd();
        chk("R11 read acts as command", status, 8'h10);
        tick();
        read_results(1, 1'b0, 1'b1, 8'h00);

        // R10: abort during execution
        wr(8'h06); tick();
        for (int i = 0; i < 8; i++) begin
            wr(8'(i));
            if (i < 7) tick();
        end
        chk("R10 in exec", status, 8'h10);
        wr(8'h1F);
        chk("R10 abort strobe in exec", {7'b0, exec_abort}, 8'h01);
        chk("R10 idle after exec abort", status, 8'h80);

        // R10: abort during results; non-abort writes there are ignored
        wr(8'h08); tick();
        for (int j = 0; j < 7; j++) exec_result[j*8 +: 8] = 8'(8'hA0 + j);
        pulse_done();
        chk("R4 first check byte", data, 8'hA0);
        wr(8'h33);
        chk("R10 other write ignored", data, 8'hA0);
        chk("R10 still returning", status, 8'hD0);
        wr(8'hFF);
        chk("R10 abort strobe in results", {7'b0, exec_abort}, 8'h01);
        chk("R10 idle after result abort", status, 8'h80);
        chk("R5 dummy after abort", data, 8'h00);

        // R12: non-DMA flag mirrored
        ndm = 1'b1;
        tick();
        chk("R12 ndm idle", status, 8'hA0);
        wr(8'h04); tick();
        chk("R12 ndm in params", status, 8'hB0);
        wr(8'h00);
        tick();
        pulse_done();
        chk("R12 ndm in results", status, 8'hF0);
        rd();
        chk("R12 ndm back idle", status, 8'hA0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule